// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block watches a small group of asynchronous interrupt pins and turns qualifying activity on each pin into a sticky per-channel flag. Each flag drives its own interrupt request output. Every channel can be set to trigger on a level or on an edge, and on either sense: active-low or active-high for levels, falling or rising for edges. After reset every channel triggers on a low level.

Software configures the unit through a narrow register port. There is one word for the trigger modes, one for the polarities, and one for the flags. Software reads the flags to find the source of a request, then clears them by writing ones. A flag that is not cleared holds its request and hides any further activity on that channel. Each pin passes through a two-flop synchroniser before it is evaluated. A per-channel enable input, driven from outside, gates whether new activity may set a flag.

Top module: `extint_unit`

## Requirements
- R1: The unit has NUM_CH channels (default 4). `irq[n]` is the flag of channel n. The flag word reads back at offset 0, with channel n at bit n.
- R2: Register offsets are: 0 = flags (write 1 to clear), 1 = trigger mode, 2 = polarity, 3 = reads zero and ignores writes. Only bits NUM_CH-1:0 are stored, and all higher read-data bits are zero.
- R3: After reset, mode, polarity and flags are all zero, so every channel triggers on a low level.
- R4: With mode bit 0 (level), polarity 0 sets the flag while the pin is low and polarity 1 sets it while the pin is high. The flag rises on the third rising clock edge after the pin change, because of two synchroniser stages plus the flag register.
- R5: With mode bit 1 (edge), polarity 0 sets the flag on a falling edge and polarity 1 sets it on a rising edge. A steady level sets nothing.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A clear wins over a trigger in the same cycle.
- R7: While a flag is set, further events on that channel are not recorded. An edge seen during that time does not reappear after the clear.
- R8: In level mode, if the active level is still present when the flag is cleared, the flag sets again one cycle later.
- R9: Writing a mode or polarity bit with a value that differs from the stored one clears that channel's flag. Writing the same value leaves the flag unchanged.
- R10: While `chanEn[n]` is 0, channel n's flag cannot be set. A flag that is already set is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIn | input | NUM_CH | Asynchronous interrupt pins |
| chanEn | input | NUM_CH | Per-channel permission to set a flag |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, combinational from `addr` |
| irq | output | NUM_CH | Per-channel interrupt request (the flags) |

## Verification
The assertions check on every cycle that:
- a written one always clears its flag, and clear has priority;
- a set flag stays set until a clear or a configuration change;
- a changed mode or polarity bit drops that channel's flag;
- a disabled channel never gains a flag;
- the flag readback mirrors `irq`, with zero upper bits.

Only the bench's scenarios can show the rest. These are the four trigger types under every pair of before and after pin values, the exact three-cycle latency, the re-arm one cycle after a clear in level mode, and the loss of an edge that arrives while the flag is already set.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_MODE = 2'd1,
    SEL_POL  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // Strobes passed from the register decoder to the datapath
  typedef struct packed {
    logic             clrFlags;
    logic             wrMode;
    logic             wrPol;
    logic [REG_W-1:0] data;
    regSel_e          rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int   WIDTH   = 4,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) stageQ[s] <= asyncIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output ctrlStrobes_t      strb
);
  localparam logic [ADDR_W-1:0] OFS_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_POL  = ADDR_W'(2);

  regSel_e sel;

  always_comb begin
    if (addr == OFS_FLAG)      sel = SEL_FLAG;
    else if (addr == OFS_MODE) sel = SEL_MODE;
    else if (addr == OFS_POL)  sel = SEL_POL;
    else                       sel = SEL_NONE;
  end

  always_comb begin
    strb.clrFlags = wrEn && (sel == SEL_FLAG);
    strb.wrMode   = wrEn && (sel == SEL_MODE);
    strb.wrPol    = wrEn && (sel == SEL_POL);
    strb.data     = wrData;
    strb.rdSel    = sel;
  end
endmodule

// File: rtl/eint_datapath.sv
module eint_datapath
  import eint_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] extIn,
  input  logic [NUM_CH-1:0] chanEn,
  input  ctrlStrobes_t      strb,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] modeVal,
  output logic [NUM_CH-1:0] polVal,
  output logic [REG_W-1:0]  rdData
);
  logic [NUM_CH-1:0] pinSync, pinPrev;
  logic [NUM_CH-1:0] modeQ, polQ, flagQ;
  logic [NUM_CH-1:0] wrBits, killMask, hitVec;
  logic              unusedHi;

  assign wrBits   = strb.data[NUM_CH-1:0];
  assign unusedHi = ^strb.data[REG_W-1:NUM_CH];

  eint_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(extIn), .syncOut(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '1;
    else       pinPrev <= pinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      polQ  <= '0;
    end else begin
      if (strb.wrMode) modeQ <= wrBits;
      if (strb.wrPol)  polQ  <= wrBits;
    end
  end

  // A clear, or a real change of trigger type, drops the flag
  always_comb begin
    killMask = '0;
    if (strb.clrFlags) killMask = killMask | wrBits;
    if (strb.wrMode)   killMask = killMask | (wrBits ^ modeQ);
    if (strb.wrPol)    killMask = killMask | (wrBits ^ polQ);
  end

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      logic levelHit, edgeHit;
      assign levelHit  = polQ[n] ? pinSync[n] : ~pinSync[n];
      assign edgeHit   = polQ[n] ? (pinSync[n] & ~pinPrev[n])
                                 : (~pinSync[n] & pinPrev[n]);
      assign hitVec[n] = (modeQ[n] ? edgeHit : levelHit) & chanEn[n];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            flagQ[n] <= 1'b0;
        else if (killMask[n]) flagQ[n] <= 1'b0;
        else if (hitVec[n])   flagQ[n] <= 1'b1;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      SEL_FLAG: rdData[NUM_CH-1:0] = flagQ;
      SEL_MODE: rdData[NUM_CH-1:0] = modeQ;
      SEL_POL:  rdData[NUM_CH-1:0] = polQ;
      default:  rdData = '0;
    endcase
  end

  assign irq     = flagQ;
  assign modeVal = modeQ;
  assign polVal  = polQ;
endmodule

// File: rtl/extint_unit.sv
module extint_unit
  import eint_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] extIn,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);
  ctrlStrobes_t      strb;
  logic [NUM_CH-1:0] modeVal, polVal;

  eint_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .strb(strb)
  );

  eint_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extIn(extIn), .chanEn(chanEn), .strb(strb),
    .irq(irq), .modeVal(modeVal), .polVal(polVal), .rdData(rdData)
  );
endmodule

// File: rtl/extint_unit_chk.sv
module extint_unit_chk
  import eint_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chanEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  rdData,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] modeVal,
  input logic [NUM_CH-1:0] polVal
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(2);

  logic unusedWr;
  assign unusedWr = ^wrData[REG_W-1:NUM_CH];

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:NUM_CH] == '0);

  assert_flag_mirror_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_FLAG) |-> (rdData[NUM_CH-1:0] == irq));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && addr == A_FLAG && wrData[n]) |=> !irq[n]);

      assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
        (irq[n] && !(wrEn && ((addr == A_FLAG && wrData[n]) ||
                              addr == A_MODE || addr == A_POL))) |=> irq[n]);

      assert_mode_change_R9: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && addr == A_MODE && wrData[n] != modeVal[n]) |=> !irq[n]);

      assert_pol_change_R9: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && addr == A_POL && wrData[n] != polVal[n]) |=> !irq[n]);

      assert_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
        (!chanEn[n] && !irq[n]) |=> !irq[n]);
    end
  endgenerate
endmodule

bind extint_unit extint_unit_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .irq(irq), .modeVal(modeVal), .polVal(polVal)
);

// File: tb/extint_unit_tb.sv
`timescale 1ns/1ps
module extint_unit_tb;
  localparam int NCH = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NCH-1:0] extIn, chanEn, irq;
  logic          wrEn;
  logic [1:0]    addr;
  logic [31:0]   wrData, rdData;
  int            checks = 0, errors = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  extint_unit #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .extIn(extIn), .chanEn(chanEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  logic [31:0] v;

  initial begin
    rstN = 1'b0; extIn = '1; chanEn = '1; wrEn = 1'b0; addr = '0; wrData = '0;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R3 reset defaults
    regRead(2'd0, v); check("R3 flags after reset", v, 0);
    regRead(2'd1, v); check("R3 mode after reset", v, 0);
    regRead(2'd2, v); check("R3 polarity after reset", v, 0);
    check("R1 irq after reset", {28'd0, irq}, 0);
    // R2 only low bits stored, offset 3 reads zero
    regWrite(2'd1, 32'hFFFF_FFF0); regRead(2'd1, v); check("R2 mode upper bits", v, 0);
    regWrite(2'd2, 32'hFFFF_FFFF); regRead(2'd2, v); check("R2 pol width", v, 32'hF);
    regWrite(2'd3, 32'hFFFF_FFFF); regRead(2'd3, v); check("R2 offset 3", v, 0);
    regWrite(2'd2, 0); tick(4);
    regRead(2'd0, v); check("R2 flags idle", v, 0);

    // R4 latency: ch0 level low
    extIn[0] = 1'b0;
    tick(2); regRead(2'd0, v); check("R4 not yet after 2 edges", v, 0);
    tick(1); regRead(2'd0, v); check("R4 set on third edge", v, 1);
    // R6 write 0 has no effect; write 1 clears
    regWrite(2'd0, 32'hE); regRead(2'd0, v); check("R6 write zero keeps", v, 1);
    regWrite(2'd0, 32'h1); regRead(2'd0, v); check("R6 clear", v, 0);
    tick(1); regRead(2'd0, v); check("R8 level re-arms", v, 1);
    extIn[0] = 1'b1; tick(4); regWrite(2'd0, 32'hF); tick(2);
    regRead(2'd0, v); check("R6 cleared after release", v, 0);

    // R10 enable gating
    chanEn = 4'b1110; extIn[0] = 1'b0; tick(5);
    regRead(2'd0, v); check("R10 disabled channel stays clear", v, 0);
    chanEn = 4'b1111; tick(2);
    regRead(2'd0, v); check("R10 enabled channel sets", v, 1);
    extIn[0] = 1'b1; tick(4); regWrite(2'd0, 32'hF);

    // R5 / R7: ch1 rising edge
    extIn[1] = 1'b0;
    regWrite(2'd1, 32'h2); regWrite(2'd2, 32'h2); tick(4); regWrite(2'd0, 32'hF); tick(1);
    regRead(2'd0, v); check("R5 steady level no flag", v, 0);
    extIn[1] = 1'b1; tick(4);
    regRead(2'd0, v); check("R5 rising edge sets", v, 2);
    extIn[1] = 1'b0; tick(3); extIn[1] = 1'b1; tick(3);
    regWrite(2'd0, 32'h2); tick(4);
    regRead(2'd0, v); check("R7 edge during set flag lost", v, 0);
    extIn[1] = 1'b0; tick(3); extIn[1] = 1'b1; tick(4);
    regRead(2'd0, v); check("R7 next edge recorded", v, 2);
    // R9
    regWrite(2'd1, 32'h2); regRead(2'd0, v); check("R9 same mode keeps flag", v, 2);
    regWrite(2'd2, 32'h0); regRead(2'd0, v); check("R9 polarity change clears", v, 0);
    tick(4); regRead(2'd0, v); check("R9 no false trigger", v, 0);

    // Sweep: every trigger type on each channel, every before/after pin pair
    for (int k = 0; k < 4; k++) begin
      logic [3:0] mv, pv;
      for (int n = 0; n < NCH; n++) begin
        int t = (n + k) % 4;
        mv[n] = t[1]; pv[n] = t[0];
      end
      regWrite(2'd1, {28'd0, mv}); regWrite(2'd2, {28'd0, pv});
      for (int pa = 0; pa < 16; pa++) begin
        for (int pb = 0; pb < 16; pb++) begin
          logic [3:0] a4 = 4'(pa), b4 = 4'(pb), ex;
          extIn = a4; tick(5); regWrite(2'd0, 32'hF);
          extIn = b4; tick(5);
          for (int n = 0; n < NCH; n++) begin
            if (!mv[n]) ex[n] = (a4[n] == pv[n]) || (b4[n] == pv[n]);
            else        ex[n] = (a4[n] != b4[n]) && (b4[n] == pv[n]);
          end
          regRead(2'd0, v);
          check(mv == 0 ? "R4 level sweep" : "R5 mixed trigger sweep", v, {28'd0, ex});
          check("R1 irq equals flags", {28'd0, irq}, {28'd0, ex});
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule